// File: doc/BRIEF.md
# Thirty-Two Line Prioritised Interrupt Controller

This block collects up to thirty-two active-high interrupt requests and turns them into two processor-facing outputs: a normal interrupt and a fast interrupt. Each line is set up through its own configuration word. That word picks edge or level capture, a five-bit priority where a smaller value is more urgent, and the output class the line feeds. A global mask register gates every line. Pending state can be read, cleared with an AND-write, or set from software.

Each output class has a one-shot agreement. While a class is armed, the first cycle that finds an unmasked pending line of that class disarms it, raises the output and latches the code of the winning line. The output then stays high, and the latched code stays fixed, until software writes the control register to rearm that class. Reading a class's code register returns the latched line number. If that line is edge-captured, the read also clears its pending bit, which serves as the acknowledge. Accesses are single 32-bit words on a plain address, data and strobe bus. Read data is combinational in the cycle of the read strobe, and the side effects of the access take hold at the next clock edge.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask (offset 0x04) reads 0xFFFFFFFF. Pending (offset 0x00), every line configuration word and both codes read 0, and `irq_o` and `fiq_o` are low.
- R2: The configuration word of line n sits at offset 0x1C + 4n. Priority is bits [6:2], bit 1 selects level capture (1) or edge capture (0), and bit 0 selects the fast class (1) or the normal class (0). The word reads back as written with all other bits 0. Reads of undefined or misaligned offsets (for example 0x08 or 0x05) return 0, and writes to them change nothing.
- R3: An edge-captured line sets its pending bit (bit n of offset 0x00) only in a cycle where its input is high and was low at the previous sample. It keeps that bit after the input falls, and holding the input high does not set the bit again once it is cleared.
- R4: A level-captured line is pending whenever its input is high. Its pending bit clears when the input falls.
- R5: A write to offset 0x00 ANDs the pending bits with the written data. A level line whose input is still high stays pending.
- R6: Within a class, the winner is the unmasked pending line with the smallest priority value. On a tie, the highest line number wins. Masked lines and lines of the other class never win.
- R7: When a class is armed and it has an eligible line, its output rises on the next clock edge and the winner's code is latched. The output and the code then hold. Writing the control register (offset 0x18) with bit 0 set rearms the normal class, and with bit 1 set rearms the fast class. The output drops at that edge and is evaluated again one cycle later.
- R8: Reading offset 0x10 returns the normal-class code, and reading offset 0x14 returns the fast-class code. If the coded line is edge-captured, the read clears its pending bit. A level-captured line is left pending.
- R9: A write to offset 0x9C sets pending only for the lowest set bit of the written data. That offset reads 0.
- R10: A mask write takes effect for both classes at once. Unmasking a pending line in an armed class raises that class's output on the following edge.
- R11: A line with bit 0 of its configuration word set drives `fiq_o` and never `irq_o`.
- R12: The control register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte address of the word access |
| wr_en | input | 1 | Write strobe; the write takes effect at the next edge |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; read side effects take effect at the next edge |
| rdata | output | 32 | Read data, valid in the cycle `rd_en` is high |
| irq_in | input | 32 | Interrupt request lines, active high |
| irq_o | output | 1 | Normal-class interrupt to the processor |
| fiq_o | output | 1 | Fast-class interrupt to the processor |

## Verification
The assertions assume the request lines are synchronous to `clk` and that reads and writes are never strobed in the same cycle. The bench changes `irq_in`, `rd_en` and `wr_en` only just after falling edges, one access at a time. The eligibility checks on a rising output also assume the mask and line configuration are not rewritten in the cycle before that output rises. The stimulus therefore sets up lines before raising them and changes the mask only when it intends to trigger evaluation.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CODE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FIQ_CODE = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CFG_BASE = 8'h1C;

  typedef enum logic {CLS_IRQ = 1'b0, CLS_FIQ = 1'b1} irq_class_e;
endpackage

// File: rtl/irqh_capture.sv
module irqh_capture #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] level_sel,
  input  logic [LINES-1:0] sw_set,
  input  logic             and_wr,
  input  logic [LINES-1:0] and_data,
  input  logic [LINES-1:0] ack_clr,
  output logic [LINES-1:0] pend
);
  logic [LINES-1:0] in_q;
  logic [LINES-1:0] set_v, fall_clr, wr_clr;

  always_comb begin
    set_v    = ((irq_in & ~in_q) & ~level_sel) | (irq_in & level_sel) | sw_set;
    fall_clr = ~irq_in & in_q & level_sel;
    wr_clr   = and_wr ? ~(and_data | (irq_in & level_sel)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
      pend <= '0;
    end else begin
      in_q <= irq_in;
      pend <= (pend & ~(fall_clr | wr_clr | ack_clr)) | set_v;
    end
  end
endmodule

// File: rtl/irqh_arbiter.sv
module irqh_arbiter #(
  parameter int LINES  = 32,
  parameter int PRIO_W = 5,
  parameter int IDX_W  = 5
) (
  input  logic [LINES-1:0]             req,
  input  logic [LINES-1:0][PRIO_W-1:0] prio,
  output logic                         any,
  output logic [IDX_W-1:0]             win
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best = '1;
    win  = '0;
    any  = |req;
    for (int i = 0; i < LINES; i++) begin
      if (req[i] && (prio[i] <= best)) begin
        best = prio[i];
        win  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqh_agree.sv
module irqh_agree #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             any,
  input  logic [IDX_W-1:0] win,
  output logic             out,
  output logic [IDX_W-1:0] code
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      out   <= 1'b0;
      code  <= '0;
    end else if (rearm) begin
      armed <= 1'b1;
      out   <= 1'b0;
    end else if (armed && any) begin
      armed <= 1'b0;
      out   <= 1'b1;
      code  <= win;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irqh_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int PRIO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int CFG_W = PRIO_W + 2;
  localparam logic [ADDR_W-1:0] OFS_SWT = ADDR_W'(int'(OFS_CFG_BASE) + 4 * LINES);

  logic [LINES-1:0]             mask_q, lvl_q, fiq_q, pend;
  logic [LINES-1:0][PRIO_W-1:0] prio_q;
  logic [ADDR_W-1:0]            cfg_off;
  logic [IDX_W-1:0]             cfg_idx;
  logic                         cfg_hit, pend_wr, ctrl_wr;
  logic [LINES-1:0]             sw_set, ack_clr;
  logic [LINES-1:0]             wlow;
  logic [1:0]                   cls_out;
  logic [IDX_W-1:0]             cls_code [2];
  logic [IDX_W-1:0]             irq_code, fiq_code;

  // Address decode
  always_comb begin
    cfg_off = addr - OFS_CFG_BASE;
    cfg_idx = cfg_off[IDX_W+1:2];
    cfg_hit = (addr[1:0] == 2'b00) && (addr >= OFS_CFG_BASE) && (addr < OFS_SWT);
    pend_wr = wr_en && (addr == OFS_PEND);
    ctrl_wr = wr_en && (addr == OFS_CTRL);
    wlow    = wdata[LINES-1:0];
    sw_set  = (wr_en && addr == OFS_SWT) ? (wlow & (~wlow + LINES'(1))) : '0;
  end

  // Acknowledge: reading a code clears that line when edge captured
  always_comb begin
    ack_clr = '0;
    if (rd_en && addr == OFS_IRQ_CODE) ack_clr = ack_clr | (LINES'(1) << irq_code);
    if (rd_en && addr == OFS_FIQ_CODE) ack_clr = ack_clr | (LINES'(1) << fiq_code);
    ack_clr = ack_clr & ~lvl_q;
  end

  // Mask and per-line configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      lvl_q  <= '0;
      fiq_q  <= '0;
      prio_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_MASK) mask_q <= wlow;
      if (cfg_hit) begin
        prio_q[cfg_idx] <= wdata[PRIO_W+1:2];
        lvl_q[cfg_idx]  <= wdata[1];
        fiq_q[cfg_idx]  <= wdata[0];
      end
    end
  end

  irqh_capture #(.LINES(LINES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .level_sel(lvl_q),
    .sw_set   (sw_set),
    .and_wr   (pend_wr),
    .and_data (wlow),
    .ack_clr  (ack_clr),
    .pend     (pend)
  );

  // One arbiter and agreement unit per output class
  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [LINES-1:0] req;
    logic             any;
    logic [IDX_W-1:0] win;

    assign req = pend & ~mask_q &
                 ((irq_class_e'(c) == CLS_FIQ) ? fiq_q : ~fiq_q);

    irqh_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
      .req (req),
      .prio(prio_q),
      .any (any),
      .win (win)
    );

    irqh_agree #(.IDX_W(IDX_W)) u_agr (
      .clk  (clk),
      .rst_n(rst_n),
      .rearm(ctrl_wr && wdata[c]),
      .any  (any),
      .win  (win),
      .out  (cls_out[c]),
      .code (cls_code[c])
    );
  end

  assign irq_code = cls_code[0];
  assign fiq_code = cls_code[1];
  assign irq_o    = cls_out[0];
  assign fiq_o    = cls_out[1];

  // Read mux
  always_comb begin
    rdata = '0;
    if (cfg_hit) begin
      rdata = DATA_W'({prio_q[cfg_idx], lvl_q[cfg_idx], fiq_q[cfg_idx]});
    end else begin
      case (addr)
        OFS_PEND:     rdata = DATA_W'(pend);
        OFS_MASK:     rdata = DATA_W'(mask_q);
        OFS_IRQ_CODE: rdata = DATA_W'(irq_code);
        OFS_FIQ_CODE: rdata = DATA_W'(fiq_code);
        default:      rdata = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{CFG_W, cfg_off[ADDR_W-1:IDX_W+2], cfg_off[1:0]};
endmodule

// File: rtl/irqh_checker.sv
module irqh_checker #(
  parameter int LINES = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       addr,
  input logic [31:0]      wdata,
  input logic [LINES-1:0] irq_in,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] lvl_q,
  input logic [LINES-1:0] fiq_q,
  input logic [LINES-1:0] mask_q,
  input logic [LINES-1:0] ack_clr,
  input logic             pend_wr,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [IDX_W-1:0] irq_code,
  input logic [IDX_W-1:0] fiq_code
);
  logic [LINES-1:0] elig_irq_d, elig_fiq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_irq_d <= '0;
      elig_fiq_d <= '0;
    end else begin
      elig_irq_d <= pend & ~mask_q & ~fiq_q;
      elig_fiq_d <= pend & ~mask_q & fiq_q;
    end
  end

  // R4: a level line seen high is pending one edge later
  a_r4_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_in) & $past(lvl_q)) & ~pend) == '0));

  // R3: edge lines lose pending only through a pending write or an acknowledge
  a_r3_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && ack_clr == '0) |=> (($past(pend & ~lvl_q) & ~pend) == '0));

  // R6: a rising normal output names a line that was eligible
  a_r6_irq_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> elig_irq_d[irq_code]);

  // R11: a rising fast output names a fast-class line that was eligible
  a_r11_fiq_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> elig_fiq_d[fiq_code]);

  // R7: while the output holds, its code holds
  a_r7_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (!irq_o || $stable(irq_code)));

  // R7: a rearm write drops the output at the next edge
  a_r7_rearm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h18 && wdata[0]) |=> !irq_o);
endmodule

bind irq_hub irqh_checker #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq_in  (irq_in),
  .pend    (pend),
  .lvl_q   (lvl_q),
  .fiq_q   (fiq_q),
  .mask_q  (mask_q),
  .ack_clr (ack_clr),
  .pend_wr (pend_wr),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .irq_code(irq_code),
  .fiq_code(fiq_code)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] irq_in = '0;
  logic        irq_o, fiq_o;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .irq_in(irq_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // Monitor: pops the expected read value and compares mid-cycle
  initial forever begin
    @(negedge clk);
    #2;
    if (rd_en && exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  function automatic logic [7:0] cfg_a(input int n);
    return 8'(8'h1C + 4 * n);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(8'h04, 32'hFFFF_FFFF, "R1 mask");
    rd(8'h00, 32'h0, "R1 pending");
    rd(cfg_a(5), 32'h0, "R1 cfg5");
    rd(8'h10, 32'h0, "R1 irq code");
    rd(8'h14, 32'h0, "R1 fiq code");
    chk(irq_o, 1'b0, "R1 irq_o");
    chk(fiq_o, 1'b0, "R1 fiq_o");

    // R2 configuration layout, undefined offsets
    wr(cfg_a(3), 32'h0000_005E);
    rd(cfg_a(3), 32'h0000_005E, "R2 cfg3 readback");
    wr(cfg_a(4), 32'hFFFF_FFFF);
    rd(cfg_a(4), 32'h0000_007F, "R2 cfg4 width");
    rd(8'h08, 32'h0, "R2 undefined read");
    wr(8'h0C, 32'h0);
    wr(8'h05, 32'h0);
    rd(8'h04, 32'hFFFF_FFFF, "R2 stray writes ignored");
    wr(cfg_a(3), 32'h0);
    wr(cfg_a(4), 32'h0);

    // R3 edge capture
    irq_in[2] = 1'b1; tick(2);
    rd(8'h00, 32'h0000_0004, "R3 edge set");
    irq_in[2] = 1'b0; tick(2);
    rd(8'h00, 32'h0000_0004, "R3 edge kept after fall");
    wr(8'h00, 32'h0);
    irq_in[2] = 1'b1; tick(2);
    wr(8'h00, 32'h0); tick(2);
    rd(8'h00, 32'h0, "R3 no recapture while held");
    irq_in[2] = 1'b0;

    // R4 / R5 level capture and AND-write
    wr(cfg_a(7), 32'h2);
    irq_in[7] = 1'b1; tick(2);
    rd(8'h00, 32'h0000_0080, "R4 level set");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0000_0080, "R5 level held through clear");
    irq_in[7] = 1'b0; tick(2);
    rd(8'h00, 32'h0, "R4 level drops on fall");
    irq_in[2] = 1'b1; irq_in[9] = 1'b1; tick(2);
    irq_in[2] = 1'b0; irq_in[9] = 1'b0;
    wr(8'h00, 32'h0000_0004);
    rd(8'h00, 32'h0000_0004, "R5 AND write");
    wr(8'h00, 32'h0);

    // R6 / R7 / R8 / R10 arbitration and agreement
    wr(cfg_a(1), 32'h0C);
    wr(cfg_a(20), 32'h0C);
    wr(cfg_a(10), 32'h04);
    wr(cfg_a(5), 32'h08);
    irq_in[1] = 1'b1; irq_in[20] = 1'b1; irq_in[10] = 1'b1; tick(2);
    chk(irq_o, 1'b0, "R10 all masked");
    wr(8'h04, ~((32'h1 << 1) | (32'h1 << 20)));
    chk(irq_o, 1'b0, "R7 one edge after mask write");
    tick(1);
    chk(irq_o, 1'b1, "R10 unmask raises irq");
    rd(8'h10, 32'd20, "R6 tie takes highest line");
    rd(8'h00, 32'h0000_0402, "R8 edge ack clears line");
    chk(irq_o, 1'b1, "R7 output holds");
    irq_in[1] = 1'b0; irq_in[20] = 1'b0; irq_in[10] = 1'b0;
    wr(8'h18, 32'h1);
    chk(irq_o, 1'b0, "R7 rearm drops output");
    tick(1);
    chk(irq_o, 1'b1, "R7 re-evaluated after rearm");
    rd(8'h10, 32'd1, "R7 new code");
    wr(8'h18, 32'h1);
    tick(2);
    chk(irq_o, 1'b0, "R6 masked line never wins");
    irq_in[5] = 1'b1; tick(2);
    wr(8'h04, ~((32'h1 << 5) | (32'h1 << 10)));
    tick(1);
    chk(irq_o, 1'b1, "R10 unmask second pair");
    rd(8'h10, 32'd10, "R6 smaller priority value wins");
    wr(8'h00, 32'h0);
    irq_in[5] = 1'b0;
    wr(8'h18, 32'h1);
    tick(2);
    chk(irq_o, 1'b0, "R7 no eligible after rearm");

    // R11 / R8 / R12 fast class
    wr(cfg_a(12), 32'h1);
    wr(cfg_a(13), 32'h3);
    wr(8'h04, ~((32'h1 << 12) | (32'h1 << 13)));
    irq_in[12] = 1'b1; tick(2);
    chk(fiq_o, 1'b1, "R11 fast line raises fiq");
    chk(irq_o, 1'b0, "R11 fast line leaves irq");
    rd(8'h14, 32'd12, "R8 fiq code");
    wr(8'h18, 32'h2);
    chk(fiq_o, 1'b0, "R7 fiq rearm drops");
    rd(8'h18, 32'h0, "R12 control reads zero");
    irq_in[13] = 1'b1; tick(2);
    chk(fiq_o, 1'b1, "R11 level fast line");
    rd(8'h14, 32'd13, "R8 fiq code level");
    rd(8'h00, 32'h0000_2000, "R8 level line not acked");
    irq_in[13] = 1'b0; irq_in[12] = 1'b0; tick(2);
    rd(8'h00, 32'h0, "R4 level fast line drops");

    // R9 software trigger
    wr(8'h9C, 32'h0000_0300);
    rd(8'h00, 32'h0000_0100, "R9 lowest set bit only");
    rd(8'h9C, 32'h0, "R9 reads zero");
    wr(8'h00, 32'h0);

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule